// File: doc/BRIEF.md
# Dual-Mode Host Bus Front End

This block sits between a host processor and the core of a display controller. The host reaches it either over an 8-bit parallel bus or over a write-only serial stream, and a strap pin picks between the two. On the parallel side a second strap chooses the strobe convention: an enable plus read/write line (6800 style), or separate active-low read and write strobes (8080 style). Every transfer is qualified by a pair of chip-select inputs, one active low and one active high.

All host pins are brought into the system clock domain through a synchronizer chain, and edges are detected there. Each completed write gives the core one byte, a one-cycle valid pulse and a flag that tells display data from a command. Each parallel read gives the core a one-cycle request pulse. The block then drives the data bus with the byte it captured while the host holds the read strobe. That byte is the core's read data for a data read and the status byte input for a command-register read. The data bus is modelled as an output value plus an output enable for a tri-state pad.

In serial mode, bus bit 6 carries the serial clock and bus bit 7 carries the serial data. A bit counter sized from the byte width collects one byte, and any partial byte is discarded whenever the chip is deselected.

Top module: `host_bus_frontend`

## Requirements
- R1: The block is selected only while `cs_n_i` is 0 and `cs_i` is 1. Under any other combination, strobes cause no write pulse and no read request, and `db_oe_o` stays 0.
- R2: `par_mode_i` = 1 selects the parallel bus and 0 the serial stream. In serial mode `db_i[6]` is the serial clock and `db_i[7]` the serial data, toggling `strobe_a_i`/`strobe_b_i` causes no write and no read, and `db_oe_o` stays 0.
- R3: With `style68_i` = 1, `strobe_a_i` is the enable and `strobe_b_i` the read/write line (1 = read). A falling enable while read/write is 0 writes the byte on `db_i[7:0]`. Enable at 1 with read/write at 1 is a read.
- R4: With `style68_i` = 0, `strobe_b_i` is the active-low write strobe and `strobe_a_i` the active-low read strobe. A rising write strobe writes the byte on `db_i[7:0]`, and a low read strobe is a read.
- R5: In serial mode, data is sampled on each rising serial clock, first bit into bit 7. The assembled byte is delivered on the eighth rising clock.
- R6: Deselecting the chip clears the serial shift register and bit counter. The next selected session starts from bit 7 of a fresh byte.
- R7: `wr_is_data_o` and `rd_is_data_o` equal `rs_i` at the transfer: 1 = display data, 0 = command/status.
- R8: Each completed write gives exactly one single-cycle `wr_valid_o` pulse. It rises on the third rising clock after the completing strobe edge appears at the pins.
- R9: Each parallel read gives exactly one single-cycle `rd_req_o` pulse. The block samples `core_rd_data_i` (`rs_i` = 1) or `status_i` (`rs_i` = 0) in the cycle `rd_req_o` is high. It drives that byte with `db_oe_o` = 1 until the read strobe is released; `db_oe_o` falls within three clocks of the release.
- R10: After reset, `wr_valid_o`, `rd_req_o` and `db_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low chip select |
| cs_i | input | 1 | Active-high chip select |
| par_mode_i | input | 1 | Strap: 1 parallel, 0 serial |
| style68_i | input | 1 | Strap: 1 enable+read/write style, 0 separate read/write strobes |
| rs_i | input | 1 | Register select: 1 display data, 0 command |
| strobe_a_i | input | 1 | Enable (6800 style) or read strobe, active low (8080 style) |
| strobe_b_i | input | 1 | Read/write line (6800 style) or write strobe, active low (8080 style) |
| db_i | input | 8 | Data bus as seen from the pads; bits 6/7 are serial clock/data in serial mode |
| db_o | output | 8 | Data bus value driven during reads |
| db_oe_o | output | 1 | Data bus output enable |
| wr_valid_o | output | 1 | One-cycle pulse per completed write |
| wr_data_o | output | 8 | Written byte, valid with `wr_valid_o` |
| wr_is_data_o | output | 1 | Data/command flag of the written byte |
| rd_req_o | output | 1 | One-cycle pulse per parallel read |
| rd_is_data_o | output | 1 | Data/status flag of the read |
| core_rd_data_i | input | 8 | Display data byte from the core |
| status_i | input | 8 | Status byte from the core |

## Verification
A stale edge-detector register shows at the ports as a second `wr_valid_o` or `rd_req_o` pulse, or as a missing one, within three clocks of the strobe edge. A serial counter that is not cleared on deselect shows at the next selected session, which delivers a byte early with bits from the aborted one, so the check compares the data and the pulse count after a full eight-bit frame. A wrong select or mode qualifier shows as `db_oe_o` rising while the host is deselected or in serial mode. The bench watches for that every cycle.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
   // bus strobe convention chosen by the style strap
   typedef enum logic {
      STYLE_SPLIT  = 1'b0,   // separate active-low read / write strobes
      STYLE_ENABLE = 1'b1    // enable plus read/write level
   } bus_style_e;

   // extra synchronized pins beside the data bus
   localparam int unsigned CTRL_PINS = 7;

   function automatic int unsigned cnt_width(input int unsigned bits);
      return (bits <= 2) ? 1 : $clog2(bits);
   endfunction
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbi_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("hbi_sync: W must be positive");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hbi_par_ctrl.sv
module hbi_par_ctrl
   import hbi_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,    // selected for two cycles and parallel mode
   input  logic style_i,     // bus_style_e value
   input  logic str_a_i,     // synchronized strobe A
   input  logic str_b_i,     // synchronized strobe B
   output logic wr_fire_o,
   output logic rd_act_o
);
   logic a_q, b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= 1'b0;
         b_q <= 1'b0;
      end else begin
         a_q <= str_a_i;
         b_q <= str_b_i;
      end
   end

   bus_style_e style;
   assign style = bus_style_e'(style_i);

   always_comb begin
      wr_fire_o = 1'b0;
      rd_act_o  = 1'b0;
      if (active_i) begin
         unique case (style)
            STYLE_ENABLE: begin
               wr_fire_o = a_q & ~str_a_i & ~str_b_i;
               rd_act_o  = str_a_i & str_b_i;
            end
            STYLE_SPLIT: begin
               wr_fire_o = ~b_q & str_b_i;
               rd_act_o  = ~str_a_i;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/hbi_ser_shift.sv
module hbi_ser_shift #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned CNT_W = hbi_pkg::cnt_width(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              sclk_i,
   input  logic              sdat_i,
   output logic              fire_o,
   output logic [DATA_W-1:0] byte_o,
   output logic [CNT_W-1:0]  cnt_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;
   logic              sclk_q;
   logic              rise;

   assign rise = active_i & sclk_i & ~sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         cnt    <= '0;
         sclk_q <= 1'b0;
      end else begin
         sclk_q <= sclk_i;
         if (!active_i) begin
            shreg <= '0;
            cnt   <= '0;
         end else if (rise) begin
            shreg <= {shreg[DATA_W-2:0], sdat_i};
            cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end
      end
   end

   assign fire_o = rise && (cnt == LAST);
   assign byte_o = {shreg[DATA_W-2:0], sdat_i};
   assign cnt_o  = cnt;
endmodule

// File: rtl/host_bus_frontend.sv
module host_bus_frontend #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SCLK_BIT    = 6,
   parameter int unsigned SDAT_BIT    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              cs_i,
   input  logic              par_mode_i,
   input  logic              style68_i,
   input  logic              rs_i,
   input  logic              strobe_a_i,
   input  logic              strobe_b_i,
   input  logic [DATA_W-1:0] db_i,
   output logic [DATA_W-1:0] db_o,
   output logic              db_oe_o,
   output logic              wr_valid_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              wr_is_data_o,
   output logic              rd_req_o,
   output logic              rd_is_data_o,
   input  logic [DATA_W-1:0] core_rd_data_i,
   input  logic [DATA_W-1:0] status_i
);
   import hbi_pkg::*;

   localparam int unsigned SV_W  = DATA_W + CTRL_PINS;
   localparam int unsigned CNT_W = cnt_width(DATA_W);
   localparam int unsigned I_SB  = DATA_W;
   localparam int unsigned I_SA  = DATA_W + 1;
   localparam int unsigned I_RS  = DATA_W + 2;
   localparam int unsigned I_STY = DATA_W + 3;
   localparam int unsigned I_PAR = DATA_W + 4;
   localparam int unsigned I_CS  = DATA_W + 5;
   localparam int unsigned I_CSN = DATA_W + 6;
   localparam logic [SV_W-1:0] SYNC_RST = SV_W'(1) << I_CSN;

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("host_bus_frontend: DATA_W too small");
      end
      if (SCLK_BIT >= DATA_W || SDAT_BIT >= DATA_W || SCLK_BIT == SDAT_BIT) begin : g_bad_pins
         $error("host_bus_frontend: serial pin positions invalid");
      end
   endgenerate

   // ---------------- synchronizers ----------------
   logic [SV_W-1:0] pins_raw, pins_s;
   assign pins_raw = {cs_n_i, cs_i, par_mode_i, style68_i, rs_i,
                      strobe_a_i, strobe_b_i, db_i};

   hbi_sync #(.W(SV_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (pins_raw),
      .q_o  (pins_s)
   );

   logic [DATA_W-1:0] db_s;
   logic sel_s, sel_q, sel_ok, par_s, rs_s;
   assign db_s   = pins_s[DATA_W-1:0];
   assign sel_s  = ~pins_s[I_CSN] & pins_s[I_CS];
   assign par_s  = pins_s[I_PAR];
   assign rs_s   = pins_s[I_RS];
   assign sel_ok = sel_s & sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= sel_s;
   end

   // ---------------- parallel path ----------------
   logic par_wr, par_rd_act;
   hbi_par_ctrl u_par (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (sel_ok & par_s),
      .style_i  (pins_s[I_STY]),
      .str_a_i  (pins_s[I_SA]),
      .str_b_i  (pins_s[I_SB]),
      .wr_fire_o(par_wr),
      .rd_act_o (par_rd_act)
   );

   // ---------------- serial path ----------------
   logic              ser_wr;
   logic [DATA_W-1:0] ser_byte;
   logic [CNT_W-1:0]  ser_cnt;
   hbi_ser_shift #(.DATA_W(DATA_W)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .active_i(sel_ok & ~par_s),
      .sclk_i  (db_s[SCLK_BIT]),
      .sdat_i  (db_s[SDAT_BIT]),
      .fire_o  (ser_wr),
      .byte_o  (ser_byte),
      .cnt_o   (ser_cnt)
   );

   // ---------------- core-side outputs ----------------
   logic              rd_act_q;
   logic [DATA_W-1:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_valid_o   <= 1'b0;
         wr_data_o    <= '0;
         wr_is_data_o <= 1'b0;
         rd_req_o     <= 1'b0;
         rd_is_data_o <= 1'b0;
         rd_act_q     <= 1'b0;
         db_oe_o      <= 1'b0;
         hold         <= '0;
      end else begin
         wr_valid_o <= par_wr | ser_wr;
         if (par_wr | ser_wr) begin
            wr_data_o    <= par_s ? db_s : ser_byte;
            wr_is_data_o <= rs_s;
         end
         rd_act_q <= par_rd_act;
         db_oe_o  <= par_rd_act;
         rd_req_o <= par_rd_act & ~rd_act_q;
         if (par_rd_act & ~rd_act_q) rd_is_data_o <= rs_s;
         if (rd_req_o) hold <= rd_is_data_o ? core_rd_data_i : status_i;
      end
   end

   assign db_o = hold;
endmodule

// File: rtl/hbi_frontend_chk.sv
module hbi_frontend_chk #(
   parameter int unsigned CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_valid,
   input logic             rd_req,
   input logic             db_oe,
   input logic             sel_s,
   input logic             sel_ok,
   input logic             par_s,
   input logic [CNT_W-1:0] ser_cnt
);
   // R8: write strobe yields a single-cycle pulse
   p_wr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);

   // R9: read request is a single-cycle pulse
   p_rd_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   // R9: the bus is driven whenever a read is requested
   p_rd_drives_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> db_oe);

   // R1: bus drive only follows a selected parallel cycle
   p_oe_needs_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
      db_oe |-> $past(sel_ok && par_s));

   // R2: no drive in serial mode
   p_no_oe_serial_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!par_s) |-> !db_oe);

   // R6: deselect clears the serial bit counter
   p_ser_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_s |=> (ser_cnt == '0));
endmodule

bind host_bus_frontend hbi_frontend_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_valid(wr_valid_o),
   .rd_req  (rd_req_o),
   .db_oe   (db_oe_o),
   .sel_s   (sel_s),
   .sel_ok  (sel_ok),
   .par_s   (par_s),
   .ser_cnt (ser_cnt)
);

// File: tb/tb_host_bus_frontend.sv
module tb_host_bus_frontend;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n;
   logic       cs_n, cs, par, sty, rs, sa, sb;
   logic [7:0] db_i, db_o, wr_data, core_d, stat;
   logic       db_oe, wr_valid, wr_is_data, rd_req, rd_is_data;

   host_bus_frontend dut (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .cs_i(cs), .par_mode_i(par),
      .style68_i(sty), .rs_i(rs), .strobe_a_i(sa), .strobe_b_i(sb),
      .db_i(db_i), .db_o(db_o), .db_oe_o(db_oe), .wr_valid_o(wr_valid),
      .wr_data_o(wr_data), .wr_is_data_o(wr_is_data), .rd_req_o(rd_req),
      .rd_is_data_o(rd_is_data), .core_rd_data_i(core_d), .status_i(stat));

   int total = 0, bad = 0;
   int wr_cnt = 0, rd_cnt = 0, dbl = 0;
   logic [7:0] last_wr = '0;
   logic last_flag = 1'b0, oe_seen = 1'b0, pv_wv = 1'b0, pv_rr = 1'b0;

   // monitor samples 1 ns after each rising edge
   always @(posedge clk) begin
      #1;
      if (wr_valid) begin wr_cnt++; last_wr = wr_data; last_flag = wr_is_data; end
      if (rd_req) rd_cnt++;
      if ((wr_valid && pv_wv) || (rd_req && pv_rr)) dbl++;
      pv_wv = wr_valid;
      pv_rr = rd_req;
      if (db_oe) oe_seen = 1'b1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic deselect();
      cs_n = 1'b1; cs = 1'b0; cyc(4);
   endtask

   task automatic select();
      cs_n = 1'b0; cs = 1'b1; cyc(4);
   endtask

   task automatic t_reset();
      chk("R10 wr_valid", wr_valid, 0);
      chk("R10 rd_req", rd_req, 0);
      chk("R10 db_oe", db_oe, 0);
      chk("R10 no pulses", wr_cnt + rd_cnt, 0);
   endtask

   // enable style write, with R8 latency checks
   task automatic t_enable_write(input logic [7:0] b, input logic f);
      int c0;
      deselect(); par = 1; sty = 1; sa = 0; sb = 0; rs = f; db_i = b;
      select(); c0 = wr_cnt;
      sa = 1; cyc(4);
      sa = 0; cyc(2);
      chk("R8 no pulse before third edge", wr_valid, 0);
      cyc(1);
      chk("R8 pulse on third edge", wr_valid, 1);
      cyc(1);
      chk("R8 pulse width one cycle", wr_valid, 0);
      cyc(3);
      chk("R3 enable write count", wr_cnt - c0, 1);
      chk("R3 enable write data", last_wr, b);
      chk("R7 write flag", last_flag, f);
   endtask

   task automatic t_split_write(input logic [7:0] b, input logic f);
      int c0;
      deselect(); par = 1; sty = 0; sa = 1; sb = 1; rs = f; db_i = b;
      select(); c0 = wr_cnt;
      sb = 0; cyc(4);
      chk("R4 no write on falling strobe", wr_cnt - c0, 0);
      sb = 1; cyc(6);
      chk("R4 split write count", wr_cnt - c0, 1);
      chk("R4 split write data", last_wr, b);
      chk("R7 split write flag", last_flag, f);
   endtask

   task automatic t_enable_read(input logic f);
      int r0;
      deselect(); par = 1; sty = 1; sa = 0; sb = 1; rs = f; db_i = '0;
      core_d = 8'h3C; stat = 8'h81;
      select(); r0 = rd_cnt; oe_seen = 0;
      sa = 1; cyc(8);
      chk("R3 read drives bus", db_oe, 1);
      chk("R9 read byte", db_o, f ? 8'h3C : 8'h81);
      chk("R9 one request", rd_cnt - r0, 1);
      chk("R7 read flag", rd_is_data, f);
      sa = 0; cyc(3);
      chk("R9 bus released", db_oe, 0);
   endtask

   task automatic t_split_read(input logic f);
      int r0;
      deselect(); par = 1; sty = 0; sa = 1; sb = 1; rs = f;
      core_d = 8'hC7; stat = 8'h10;
      select(); r0 = rd_cnt;
      sa = 0; cyc(10);
      chk("R4 read drives bus", db_oe, 1);
      chk("R9 split read byte", db_o, f ? 8'hC7 : 8'h10);
      chk("R9 split one request", rd_cnt - r0, 1);
      chk("R7 split read flag", rd_is_data, f);
      sa = 1; cyc(3);
      chk("R9 split bus released", db_oe, 0);
   endtask

   task automatic t_deselected();
      int c0, r0;
      par = 1; sty = 0; sa = 1; sb = 1;
      for (int k = 0; k < 2; k++) begin
         if (k == 0) begin cs_n = 1; cs = 1; end
         else        begin cs_n = 0; cs = 0; end
         cyc(4); c0 = wr_cnt; r0 = rd_cnt; oe_seen = 0;
         sb = 0; cyc(4); sb = 1; cyc(4);
         sa = 0; cyc(6); sa = 1; cyc(4);
         chk("R1 no write while deselected", wr_cnt - c0, 0);
         chk("R1 no read while deselected", rd_cnt - r0, 0);
         chk("R1 bus floats while deselected", oe_seen, 0);
      end
   endtask

   task automatic ser_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         db_i = {b[i], 1'b0, 6'h2A}; cyc(4);
         db_i[6] = 1'b1; cyc(4);
         db_i[6] = 1'b0; cyc(4);
      end
   endtask

   task automatic t_serial(input logic [7:0] b, input logic f);
      int c0;
      deselect(); par = 0; rs = f; sa = 0; sb = 0; db_i = '0;
      select(); c0 = wr_cnt;
      ser_bits(b, 7);
      chk("R5 nothing before eighth clock", wr_cnt - c0, 0);
      ser_bits(b << 7, 1);
      cyc(2);
      chk("R5 serial byte count", wr_cnt - c0, 1);
      chk("R5 serial byte msb first", last_wr, b);
      chk("R7 serial flag", last_flag, f);
   endtask

   task automatic t_serial_abort();
      int c0;
      deselect(); par = 0; rs = 1; db_i = '0;
      select(); c0 = wr_cnt;
      ser_bits(8'hFF, 3);
      deselect(); select();
      ser_bits(8'hA5, 5);
      chk("R6 partial byte discarded", wr_cnt - c0, 0);
      ser_bits(8'hA5 << 5, 3);
      cyc(2);
      chk("R6 fresh byte count", wr_cnt - c0, 1);
      chk("R6 fresh byte data", last_wr, 8'hA5);
   endtask

   task automatic t_serial_strobes();
      int c0, r0;
      deselect(); par = 0; sty = 0; sa = 1; sb = 1; rs = 0; db_i = 8'h00;
      select(); c0 = wr_cnt; r0 = rd_cnt; oe_seen = 0;
      sb = 0; cyc(4); sb = 1; cyc(4);
      sa = 0; cyc(6); sa = 1; cyc(4);
      sty = 1; sb = 0; sa = 1; cyc(4); sa = 0; cyc(4);
      chk("R2 strobes ignored in serial", wr_cnt - c0, 0);
      chk("R2 no read in serial", rd_cnt - r0, 0);
      chk("R2 bus floats in serial", oe_seen, 0);
   endtask

   initial begin
      #(200000 * 5);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 0; cs_n = 1; cs = 0; par = 1; sty = 0; rs = 0;
      sa = 1; sb = 1; db_i = '0; core_d = '0; stat = '0;
      cyc(4); rst_n = 1; cyc(6);
      t_reset();
      t_enable_write(8'h5A, 1'b1);
      t_enable_write(8'h0F, 1'b0);
      t_split_write(8'h96, 1'b1);
      t_split_write(8'h01, 1'b0);
      t_enable_read(1'b1);
      t_enable_read(1'b0);
      t_split_read(1'b1);
      t_split_read(1'b0);
      t_deselected();
      t_serial(8'hB3, 1'b1);
      t_serial(8'h4C, 1'b0);
      t_serial_abort();
      t_serial_strobes();
      deselect();
      chk("R8 no double pulses", dbl, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule